// File: doc/BRIEF.md
# Three-Voice Wavetable Sound Generator with Pulse-Width Output

This block produces the audio of a small game system. A processor writes pitch, timbre and loudness settings for three voices into a 32-location register window, one nibble per write. A divider raises a sample tick at a fixed rate (96 kHz in the intended clocking). On every tick, each voice adds its pitch value to a 20-bit phase accumulator. The block then reads one 4-bit sample per voice from an external synchronous waveform ROM, addressing it with the voice's waveform select and the top five phase bits. This gives 32 samples per waveform period.

The three samples are each scaled by their voice's volume and summed. The sum is multiplied by four and limited to 255 to form an 8-bit level. A free-running 8-bit counter compares against that level to drive a single-bit speaker pin. The first voice has a 20-bit pitch register. The other two have 16-bit pitch registers that are zero-extended into their accumulators. All three voices otherwise behave identically.

Top module: `wavesynth3`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rom_rd` and `pwm_out` are 0. Reset clears all registers, all accumulators and the level to 0.
- R2: The write port accepts a write on a clock edge where `wr_en` is high. The address is split into a voice number (`wr_addr[4:3]`, values 0 to 2) and a slot (`wr_addr[2:0]`), and the written value is `wr_data`.
  - For voice 0, slots 0 to 4 hold pitch nibbles 0 to 4, least significant nibble first.
  - For voices 1 and 2, slots 0 to 3 hold the four nibbles of a 16-bit pitch.
  - Slot 5 holds the waveform select in its low 3 bits.
  - Slot 6 holds the 4-bit volume.
- R3: Some writes change nothing. These are slot 4 of voices 1 and 2, slot 7 of any voice, and any address with voice number 3.
- R4: A tick occurs every `TICK_DIV` cycles. On the tick edge, every accumulator adds its pitch value, modulo 2^20. In the three following cycles, `rom_rd` is high with addresses for voices 0, 1 and 2, in that order. `rom_rd` is low at all other times.
- R5: Each ROM address is the voice's waveform select in bits 7:5, followed by accumulator bits 19:15 in bits 4:0.
- R6: The ROM returns data one cycle after the edge that presents the address. The voice sample is `rom_data[3:0]`, and `rom_data[7:4]` has no effect.
- R7: The level is min(255, 4 × the sum over the three voices of sample × volume). A volume of 0 silences its voice.
  - The level is recomputed once per tick, after the third read.
  - A volume written between ticks has no effect on the level until the next tick.
- R8: `pwm_out` is high exactly when an 8-bit free-running counter is below the level. Over any 256 consecutive cycles with a constant level, `pwm_out` is high for exactly that many cycles, so a level of 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register window offset: voice in [4:3], slot in [2:0] |
| wr_data | input | 4 | Nibble written to the addressed slot |
| rom_rd | output | 1 | Waveform ROM read strobe |
| rom_addr | output | 8 | Waveform ROM address {waveform, phase[19:15]} |
| rom_data | input | 8 | Waveform ROM data, one cycle after the address |
| pwm_out | output | 1 | Pulse-width modulated speaker drive |

## Verification
Take the tick edge as cycle 0. The three ROM reads appear at the ports in cycles 1, 2 and 3, the new level is registered in cycle 6, and `pwm_out` follows it in cycle 7. The bench checks every read address and the read spacing at the falling edge of each read cycle, against an arithmetic model of the accumulators. It begins each 256-cycle duty count eight cycles after the third read, so the count lies wholly between ticks. Register writes are placed after the duty count and before the next tick. This makes the stepped model match the cycle in which the design uses each setting, and lets one extra count inside an interval show that a changed volume is held until the following tick.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int NUM_VOICES = 3;
  localparam int NIB_W      = 4;
  localparam int SLOT_W     = 3;
  typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/wsg_regs.sv
module wsg_regs
  import wsg_pkg::*;
#(
  parameter int NV       = NUM_VOICES,
  parameter int ACC_W    = 20,
  parameter int NARROW_W = 16,
  parameter int WAVE_W   = 3,
  parameter int VOL_W    = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  nibble_t                       wr_data,
  output logic [NV-1:0][ACC_W-1:0]      freq,
  output logic [NV-1:0][WAVE_W-1:0]     wave,
  output logic [NV-1:0][VOL_W-1:0]      vol
);
  localparam int WIDE_NIBS   = ACC_W / NIB_W;
  localparam int NARROW_NIBS = NARROW_W / NIB_W;
  localparam int WAVE_SLOT   = WIDE_NIBS;
  localparam int VOL_SLOT    = WIDE_NIBS + 1;
  localparam int SEL_W       = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0] slot;
  logic [SEL_W-1:0]  vsel;
  assign slot = wr_addr[SLOT_W-1:0];
  assign vsel = wr_addr[ADDR_W-1:SLOT_W];

  for (genvar v = 0; v < NV; v++) begin : g_voice
    localparam int NIBS = (v == 0) ? WIDE_NIBS : NARROW_NIBS;
    logic              hit;
    logic [ACC_W-1:0]  f_q;
    logic [WAVE_W-1:0] w_q;
    logic [VOL_W-1:0]  v_q;

    assign hit = wr_en && (vsel == SEL_W'(v));

    always_ff @(posedge clk) begin
      if (rst) begin
        f_q <= '0;
        w_q <= '0;
        v_q <= '0;
      end else if (hit) begin
        for (int n = 0; n < NIBS; n++) begin
          if (slot == SLOT_W'(n)) f_q[n*NIB_W +: NIB_W] <= wr_data;
        end
        if (slot == SLOT_W'(WAVE_SLOT)) w_q <= wr_data[WAVE_W-1:0];
        if (slot == SLOT_W'(VOL_SLOT))  v_q <= wr_data[VOL_W-1:0];
      end
    end

    assign freq[v] = f_q;
    assign wave[v] = w_q;
    assign vol[v]  = v_q;
  end
endmodule

// File: rtl/wsg_phase.sv
module wsg_phase #(
  parameter int NV       = 3,
  parameter int ACC_W    = 20,
  parameter int WAVE_W   = 3,
  parameter int PH_W     = 5,
  parameter int TICK_DIV = 1042
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NV-1:0][ACC_W-1:0]      freq,
  input  logic [NV-1:0][WAVE_W-1:0]     wave,
  output logic                          rom_rd,
  output logic [WAVE_W+PH_W-1:0]        rom_addr,
  output logic [$clog2(NV)-1:0]         rd_vid
);
  localparam int DIV_W = $clog2(TICK_DIV);
  localparam int VID_W = $clog2(NV);

  logic [DIV_W-1:0]           div_cnt;
  logic                       tick;
  logic [NV-1:0][ACC_W-1:0]   acc;
  logic                       active;
  logic [VID_W-1:0]           vsel;

  assign tick = (div_cnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  for (genvar v = 0; v < NV; v++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (tick) acc_q <= acc_q + freq[v];
    end
    assign acc[v] = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      vsel     <= '0;
      rom_rd   <= 1'b0;
      rom_addr <= '0;
      rd_vid   <= '0;
    end else begin
      rom_rd   <= active;
      rom_addr <= {wave[vsel], acc[vsel][ACC_W-1 -: PH_W]};
      rd_vid   <= vsel;
      if (tick) begin
        active <= 1'b1;
        vsel   <= '0;
      end else if (active) begin
        if (vsel == VID_W'(NV - 1)) active <= 1'b0;
        else                        vsel   <= vsel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsg_mix.sv
module wsg_mix #(
  parameter int NV     = 3,
  parameter int VOL_W  = 4,
  parameter int SMP_W  = 4,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8,
  parameter int SHIFT  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_in,
  input  logic [$clog2(NV)-1:0]       vid_in,
  input  logic [DATA_W-1:0]           rom_data,
  input  logic [NV-1:0][VOL_W-1:0]    vol,
  output logic [LVL_W-1:0]            level,
  output logic                        mix_go
);
  localparam int VID_W   = $clog2(NV);
  localparam int MIX_W   = SMP_W + VOL_W + VID_W + 1 + SHIFT;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic                       rd_d1;
  logic [VID_W-1:0]           vid_d1;
  logic [NV-1:0][SMP_W-1:0]   smp_q;
  logic [MIX_W-1:0]           mix_sum;
  logic                       unused_hi;

  assign unused_hi = ^rom_data[DATA_W-1:SMP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d1  <= 1'b0;
      vid_d1 <= '0;
      smp_q  <= '0;
      mix_go <= 1'b0;
    end else begin
      rd_d1  <= rd_in;
      vid_d1 <= vid_in;
      mix_go <= rd_d1 && (vid_d1 == VID_W'(NV - 1));
      for (int v = 0; v < NV; v++) begin
        if (rd_d1 && (vid_d1 == VID_W'(v))) smp_q[v] <= rom_data[SMP_W-1:0];
      end
    end
  end

  always_comb begin
    mix_sum = '0;
    for (int v = 0; v < NV; v++) begin
      mix_sum = mix_sum + MIX_W'(smp_q[v]) * MIX_W'(vol[v]);
    end
    mix_sum = mix_sum << SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst)         level <= '0;
    else if (mix_go) level <= (mix_sum > MIX_W'(LVL_MAX)) ? '1 : mix_sum[LVL_W-1:0];
  end
endmodule

// File: rtl/wsg_pwm.sv
module wsg_pwm #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  output logic             pwm_out
);
  logic [LVL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      pwm_out <= (cnt < level);
    end
  end
endmodule

// File: rtl/wavesynth3.sv
module wavesynth3
  import wsg_pkg::*;
#(
  parameter int TICK_DIV = 1042,
  parameter int ACC_W    = 20,
  parameter int NARROW_W = 16,
  parameter int WAVE_W   = 3,
  parameter int VOL_W    = 4,
  parameter int PH_W     = 5,
  parameter int SMP_W    = 4,
  parameter int DATA_W   = 8,
  parameter int LVL_W    = 8,
  parameter int ADDR_W   = 5,
  localparam int RA_W    = WAVE_W + PH_W,
  localparam int NV      = NUM_VOICES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  output logic              rom_rd,
  output logic [RA_W-1:0]   rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              pwm_out
);
  logic [NV-1:0][ACC_W-1:0]  freq_all;
  logic [NV-1:0][WAVE_W-1:0] wave_all;
  logic [NV-1:0][VOL_W-1:0]  vol_all;
  logic [$clog2(NV)-1:0]     rd_vid;
  logic [LVL_W-1:0]          level_q;
  logic                      mix_go;

  wsg_regs #(
    .NV(NV), .ACC_W(ACC_W), .NARROW_W(NARROW_W),
    .WAVE_W(WAVE_W), .VOL_W(VOL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq(freq_all), .wave(wave_all), .vol(vol_all)
  );

  wsg_phase #(
    .NV(NV), .ACC_W(ACC_W), .WAVE_W(WAVE_W), .PH_W(PH_W), .TICK_DIV(TICK_DIV)
  ) u_phase (
    .clk(clk), .rst(rst), .freq(freq_all), .wave(wave_all),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rd_vid(rd_vid)
  );

  wsg_mix #(
    .NV(NV), .VOL_W(VOL_W), .SMP_W(SMP_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .SHIFT(2)
  ) u_mix (
    .clk(clk), .rst(rst), .rd_in(rom_rd), .vid_in(rd_vid), .rom_data(rom_data),
    .vol(vol_all), .level(level_q), .mix_go(mix_go)
  );

  wsg_pwm #(.LVL_W(LVL_W)) u_pwm (
    .clk(clk), .rst(rst), .level(level_q), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/wavesynth3_chk.sv
module wavesynth3_chk #(
  parameter int NV    = 3,
  parameter int ACC_W = 20,
  parameter int LVL_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rom_rd,
  input logic                     pwm_out,
  input logic [LVL_W-1:0]         level,
  input logic                     mix_go,
  input logic [NV-1:0][ACC_W-1:0] freq_all
);
  localparam int RUN_W = $clog2(NV) + 2;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (rom_rd) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R1: outputs quiet right after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rom_rd && !pwm_out));

  // R2 and R3: pitch registers move only on a write strobe
  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(freq_all));

  // R4: no read burst runs longer than the voice count
  assert_burst_max_R4: assert property (@(posedge clk) disable iff (rst)
    run_len <= RUN_W'(NV));

  // R4: every burst that ends has exactly one read per voice
  assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
    (!rom_rd && run_len != '0) |-> (run_len == RUN_W'(NV)));

  // R7: level changes only right after the mix strobe
  assert_level_on_mix_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> $past(mix_go));

  // R8: a zero level keeps the speaker low
  assert_silent_pwm_R8: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !pwm_out);
endmodule

bind wavesynth3 wavesynth3_chk #(.NV(NV), .ACC_W(ACC_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rom_rd(rom_rd), .pwm_out(pwm_out),
  .level(level_q), .mix_go(mix_go), .freq_all(freq_all)
);

// File: tb/wavesynth3_tb.sv
`timescale 1ns/1ps
module wavesynth3_tb;
  localparam int TDIV = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       rom_rd;
  logic [7:0] rom_addr;
  logic [7:0] rom_data = '0;
  logic       pwm_out;

  always #2 clk = ~clk;

  wavesynth3 #(.TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data), .pwm_out(pwm_out)
  );

  // Test waveform table; the upper nibble is the complement, so using it (R6) shows up.
  function automatic logic [7:0] rom_fn(input logic [7:0] a);
    logic [3:0] lo;
    lo = 4'(a[4:0] * 3) ^ {1'b0, a[7:5]};
    return {~lo, lo};
  endfunction

  always @(posedge clk) rom_data <= rom_fn(rom_addr);

  int checks = 0, fails = 0, cyc = 0, bidx = 0, bursts = 0, last_start = -1;
  bit done = 0;
  string phase = "main";
  logic [19:0] freq_m[3];
  logic [19:0] acc_m[3];
  logic [2:0]  wave_m[3];
  logic [3:0]  vol_m[3];

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_level();
    int s = 0;
    for (int v = 0; v < 3; v++) begin
      logic [7:0] byte_v;
      byte_v = rom_fn({wave_m[v], acc_m[v][19:15]});
      s += int'(byte_v[3:0]) * int'(vol_m[v]);
    end
    s = s * 4;
    return (s > 255) ? 255 : s;
  endfunction

  // Read monitor: R4 spacing and order, R5 addressing
  always @(negedge clk) begin
    if (!rst && rom_rd) begin
      if (bidx == 0) begin
        for (int v = 0; v < 3; v++) acc_m[v] = acc_m[v] + freq_m[v];
        if (last_start >= 0) check("R4 tick spacing", cyc - last_start, TDIV);
        last_start = cyc;
      end
      check($sformatf("R5 address voice %0d (%s)", bidx, phase),
            int'(rom_addr), int'({wave_m[bidx], acc_m[bidx][19:15]}));
      bidx = (bidx == 2) ? 0 : bidx + 1;
      if (bidx == 0) bursts++;
    end else if (!rst && bidx != 0) begin
      check("R4 reads not consecutive", 0, 1);
      bidx = 0;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 4'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Model of the R2 map with the R3 ignored locations
  task automatic set_reg(input int v, input int slot, input int d);
    wr(v * 8 + slot, d);
    if (v < 3) begin
      if (slot < ((v == 0) ? 5 : 4)) freq_m[v][slot*4 +: 4] = 4'(d);
      else if (slot == 5)            wave_m[v] = 3'(d);
      else if (slot == 6)            vol_m[v]  = 4'(d);
    end
  endtask

  task automatic set_voice(input int v, input int f, input int w, input int vl);
    for (int n = 0; n < 5; n++) set_reg(v, n, (f >> (4 * n)) & 15);
    set_reg(v, 5, w);
    set_reg(v, 6, vl);
  endtask

  task automatic wait_burst();
    int b;
    b = bursts;
    wait (bursts != b);
    repeat (8) @(negedge clk);
  endtask

  task automatic measure(input string tag, input int exp);
    int hi = 0;
    repeat (256) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    check(tag, hi, exp);
  endtask

  initial begin
    for (int v = 0; v < 3; v++) begin
      freq_m[v] = '0; acc_m[v] = '0; wave_m[v] = '0; vol_m[v] = '0;
    end
    repeat (5) @(negedge clk);
    check("R1 rom_rd during reset", int'(rom_rd), 0);
    check("R1 pwm_out during reset", int'(pwm_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rom_rd after reset", int'(rom_rd), 0);
    wait_burst();
    measure("R1 R8 level zero after reset", 0);

    // R7 volume sweep on voice 0 alone (R6 via complemented upper nibble)
    set_voice(0, 20'h01234, 5, 0);
    for (int vl = 0; vl < 16; vl++) begin
      set_reg(0, 6, vl);
      wait_burst();
      measure($sformatf("R7 R6 R8 voice0 volume %0d", vl), exp_level());
    end

    // R5 waveform sweep on voice 1
    set_reg(0, 6, 0);
    for (int w = 0; w < 8; w++) begin
      set_voice(1, 16'h0900, w, 3);
      wait_burst();
      measure($sformatf("R5 R7 voice1 wave %0d", w), exp_level());
    end

    // R2 R4 wide pitch and accumulator wrap
    set_voice(0, 20'hFFFFF, 2, 7);
    set_voice(2, 16'hC000, 6, 9);
    for (int t = 0; t < 6; t++) begin
      wait_burst();
      measure($sformatf("R2 R4 wrap tick %0d", t), exp_level());
    end

    // R3 writes that must be ignored
    phase = "R3";
    set_reg(1, 4, 15);
    set_reg(2, 4, 15);
    set_reg(0, 7, 15);
    set_reg(2, 7, 15);
    for (int s = 0; s < 8; s++) set_reg(3, s, 15);
    for (int t = 0; t < 3; t++) begin
      wait_burst();
      measure($sformatf("R3 ignored writes tick %0d", t), exp_level());
    end
    phase = "main";

    // R7 clamp with all voices loud
    set_voice(0, 20'h21357, 1, 15);
    set_voice(1, 16'h3A11, 4, 15);
    set_voice(2, 16'h1F03, 7, 15);
    for (int t = 0; t < 6; t++) begin
      wait_burst();
      measure($sformatf("R7 clamp tick %0d", t), exp_level());
    end
    check("R7 clamp reached", exp_level(), 255);

    // R7 volume held until the next tick
    set_voice(0, 20'h00400, 3, 5);
    set_voice(1, 16'h0000, 0, 0);
    set_voice(2, 16'h0000, 0, 0);
    wait_burst();
    begin
      int held;
      held = exp_level();
      measure("R7 level before volume change", held);
      set_reg(0, 6, 12);
      measure("R7 level held until next tick", held);
    end
    wait_burst();
    measure("R7 level after next tick", exp_level());

    // R7 all volumes zero silences
    set_reg(0, 6, 0);
    wait_burst();
    measure("R7 R8 silent at volume 0", 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule